// File: doc/BRIEF.md
# Dual-Port Virtual UART Bridge

This block joins two byte-wide UART-style register files that sit on unrelated bus clocks. No serial line runs between them. A byte that one side writes to its transmit data register goes into a FIFO, and the opposite side reads that FIFO as received data. A second FIFO carries bytes the other way. Each FIFO holds 16 entries. Each FIFO has Gray-coded pointers and two-flop synchronizers, so it is safe for either port to run faster than the other. A typical setup has a 100 MHz side that streams console text and a 33 MHz side that consumes it.

Each port offers a small register set:
- Offset 0: written, it is the transmit data; read, it is the received data.
- Offset 2: FIFO control.
- Offset 5: line status.

Each port drives a plain one-cycle write strobe and a plain one-cycle read strobe, with no other bus protocol. A reset bit is provided for each direction. Either port can flush its own receive queue or its own transmit queue, and this frees a link that has backed up.

Top module: `vuart_bridge`

## Requirements
- R1: After reset, a read of offset 5 returns 0x60 on both ports (bit 0 data-ready clear, bit 5 holding-empty set, bit 6 transmitter-empty set, all other bits 0). A read of offset 0 returns 0x00.
- R2: Bytes written at offset 0 on port A are read at offset 0 on port B in the same order with none lost. This includes writes on every consecutive port A clock cycle.
- R3: Bytes written at offset 0 on port B are read at offset 0 on port A in the same order with none lost.
- R4: Status bit 0 (data ready) on a port reads 1 while its receive queue holds a byte, within a few reader clocks of the write. It reads 0 once the queue is drained.
- R5: Status bits 5 and 6 on the writing port read 0 from the cycle after an accepted write. They return to 1 within a few writer clocks after the other port has read every byte.
- R6: Each direction holds up to 16 bytes. A write at offset 0 while 16 bytes are pending is discarded, and the discarded byte is never delivered.
- R7: A read at offset 0 with an empty receive queue returns 0x00 and does not disturb later deliveries.
- R8: Writing offset 2 with bit 1 set discards the port's pending received bytes. Data ready reads 0 from the next cycle, and the other port's holding-empty bit returns to 1.
- R9: Writing offset 2 with bit 2 set discards the port's pending transmitted bytes. Within a few clocks of both domains, the other port's data ready reads 0 and this port's status reads 0x60.
- R10: Reads of offset 5 placed between transmit writes change neither the data delivered nor its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A bus clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_wr | input | 1 | Port A write strobe, one per cycle |
| a_rd | input | 1 | Port A read strobe, one per cycle |
| a_addr | input | 3 | Port A register offset |
| a_wdata | input | 8 | Port A write data |
| a_rdata | output | 8 | Port A read data, combinational from a_addr |
| clk_b | input | 1 | Port B bus clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_addr | input | 3 | Port B register offset |
| b_wdata | input | 8 | Port B write data |
| b_rdata | output | 8 | Port B read data, combinational from b_addr |

## Verification
The assertions assume that each port's strobes and address are stable around the rising edge of that port's own clock. They also assume that both resets are asserted together before either side runs. The bench changes every input on the falling edge of its own clock, holds both resets low for several slow-clock cycles, and then runs the two ports from independent processes. During the random phase, each writer keeps its outstanding byte count at ten or fewer, so the pointer synchronization lag can never turn an expected write into a discarded one.

// File: rtl/vuart_bridge.sv
module vuart_bridge #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [2:0]        a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [2:0]        b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_FCR  = 3'd2;
  localparam logic [2:0] OFS_LSR  = 3'd5;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // direction 0 carries A->B, direction 1 carries B->A
  logic [1:0] wclk, rclk, wrst_n, rrst_n;
  logic [1:0] w_en, w_clr, r_en, r_clr;
  logic [1:0] w_full, w_empty, r_avail;
  logic [DATA_W-1:0] w_data [2];
  logic [DATA_W-1:0] r_data [2];

  assign wclk   = {clk_b, clk_a};
  assign rclk   = {clk_a, clk_b};
  assign wrst_n = {rst_b_n, rst_a_n};
  assign rrst_n = {rst_a_n, rst_b_n};

  assign w_en[0]  = a_wr && a_addr == OFS_DATA;
  assign w_en[1]  = b_wr && b_addr == OFS_DATA;
  assign w_clr[0] = a_wr && a_addr == OFS_FCR && a_wdata[2];
  assign w_clr[1] = b_wr && b_addr == OFS_FCR && b_wdata[2];
  assign r_en[0]  = b_rd && b_addr == OFS_DATA;
  assign r_en[1]  = a_rd && a_addr == OFS_DATA;
  assign r_clr[0] = b_wr && b_addr == OFS_FCR && b_wdata[1];
  assign r_clr[1] = a_wr && a_addr == OFS_FCR && a_wdata[1];
  assign w_data[0] = a_wdata;
  assign w_data[1] = b_wdata;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rq1, rq2, wbin_n;
    logic [AW:0] rbin, rgray, wq1, wq2, rbin_n;
    logic ftog, fs1, fs2, fs3, draining;
    logic wput, rstep, rflush, rempty;

    assign w_full[d]  = wgray == {~rq2[AW:AW-1], rq2[AW-2:0]};
    assign w_empty[d] = wgray == rq2;
    assign wput       = w_en[d] && !w_full[d];
    assign wbin_n     = wbin + (AW+1)'(wput);

    always_ff @(posedge wclk[d] or negedge wrst_n[d]) begin
      if (!wrst_n[d]) begin
        wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0; ftog <= 1'b0;
      end else begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
        rq1   <= rgray;
        rq2   <= rq1;
        if (w_clr[d]) ftog <= ~ftog;
      end
    end

    always_ff @(posedge wclk[d]) begin
      if (wput) mem[wbin[AW-1:0]] <= w_data[d];
    end

    assign rempty     = rgray == wq2;
    assign rflush     = r_clr[d] || (fs2 ^ fs3);
    assign rstep      = !rempty && (draining || rflush || r_en[d]);
    assign rbin_n     = rbin + (AW+1)'(rstep);
    assign r_avail[d] = !rempty && !draining;
    assign r_data[d]  = r_avail[d] ? mem[rbin[AW-1:0]] : '0;

    always_ff @(posedge rclk[d] or negedge rrst_n[d]) begin
      if (!rrst_n[d]) begin
        rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
        fs1 <= 1'b0; fs2 <= 1'b0; fs3 <= 1'b0; draining <= 1'b0;
      end else begin
        rbin     <= rbin_n;
        rgray    <= rbin_n ^ (rbin_n >> 1);
        wq1      <= wgray;
        wq2      <= wq1;
        fs1      <= ftog;
        fs2      <= fs1;
        fs3      <= fs2;
        draining <= (draining || rflush) && !(rbin_n == g2b(wq2));
      end
    end
  end

  logic [7:0] lsr_a, lsr_b;
  assign lsr_a = {1'b0, w_empty[0], w_empty[0], 4'b0, r_avail[1]};
  assign lsr_b = {1'b0, w_empty[1], w_empty[1], 4'b0, r_avail[0]};

  always_comb begin
    case (a_addr)
      OFS_DATA: a_rdata = r_data[1];
      OFS_LSR:  a_rdata = DATA_W'(lsr_a);
      default:  a_rdata = '0;
    endcase
    case (b_addr)
      OFS_DATA: b_rdata = r_data[0];
      OFS_LSR:  b_rdata = DATA_W'(lsr_b);
      default:  b_rdata = '0;
    endcase
  end
endmodule

module vuart_bridge_chk (
  input logic       clk_a,
  input logic       rst_a_n,
  input logic       a_wr,
  input logic [2:0] a_addr,
  input logic [7:0] a_wdata,
  input logic [7:0] a_rdata,
  input logic       clk_b,
  input logic       rst_b_n,
  input logic       b_wr,
  input logic [2:0] b_addr,
  input logic [7:0] b_wdata,
  input logic [7:0] b_rdata,
  input logic [1:0] w_full,
  input logic [1:0] w_empty,
  input logic [1:0] r_avail
);
  AST_THRE_DROP_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_wr && a_addr == 3'd0 && !w_full[0]) |=> !w_empty[0]); // R5
  AST_THRE_DROP_B: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_wr && b_addr == 3'd0 && !w_full[1]) |=> !w_empty[1]); // R5
  AST_THRE_HOLD_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (w_empty[0] && !(a_wr && a_addr == 3'd0)) |=> w_empty[0]); // R5
  AST_THRE_HOLD_B: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (w_empty[1] && !(b_wr && b_addr == 3'd0)) |=> w_empty[1]); // R5
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    w_full[0] |-> !w_empty[0]); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_addr == 3'd0 && !r_avail[1]) |-> a_rdata == 8'h00); // R7
  AST_RX_CLEAR_DR: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_wr && b_addr == 3'd2 && b_wdata[1]) |=> !r_avail[0]); // R8
  AST_LSR_RESERVED: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    b_addr == 3'd5 |-> (b_rdata[7] == 1'b0 && b_rdata[4:1] == 4'd0)); // R1
  AST_RX_CLEAR_DR_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_wr && a_addr == 3'd2 && a_wdata[1]) |=> !r_avail[1]); // R8
endmodule

bind vuart_bridge vuart_bridge_chk u_chk (.*);

// File: tb/tb_vuart_bridge.sv
`timescale 1ns/1ps
module tb_vuart_bridge;
  logic clk_a = 0, clk_b = 0, rst_a_n = 0, rst_b_n = 0;
  logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [2:0] a_addr = 0, b_addr = 0;
  logic [7:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;

  always #4  clk_a = ~clk_a;
  always #15 clk_b = ~clk_b;

  vuart_bridge dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] q_ab[$], q_ba[$];

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_put(logic [2:0] ad, logic [7:0] d);
    @(negedge clk_a); a_rd = 0; a_wr = 1; a_addr = ad; a_wdata = d;
  endtask
  task automatic a_get(logic [2:0] ad, output logic [7:0] d);
    @(negedge clk_a); a_wr = 0; a_rd = 1; a_addr = ad; #1 d = a_rdata;
  endtask
  task automatic a_rel();
    @(negedge clk_a); a_wr = 0; a_rd = 0; a_addr = 3'd1;
  endtask
  task automatic b_put(logic [2:0] ad, logic [7:0] d);
    @(negedge clk_b); b_rd = 0; b_wr = 1; b_addr = ad; b_wdata = d;
  endtask
  task automatic b_get(logic [2:0] ad, output logic [7:0] d);
    @(negedge clk_b); b_wr = 0; b_rd = 1; b_addr = ad; #1 d = b_rdata;
  endtask
  task automatic b_rel();
    @(negedge clk_b); b_wr = 0; b_rd = 0; b_addr = 3'd1;
  endtask

  task automatic b_drain(string req, int n);
    logic [7:0] s, d;
    for (int i = 0; i < n; i++) begin
      bit ok = 0;
      for (int t = 0; t < 40 && !ok; t++) begin b_get(3'd5, s); ok = s[0]; end
      chk({req, " R4 data ready"}, {7'd0, ok}, 8'h01);
      if (ok) begin
        b_get(3'd0, d);
        chk(req, d, q_ab.size() ? q_ab.pop_front() : 8'hxx);
      end
    end
    b_rel();
  endtask

  task automatic a_drain(string req, int n);
    logic [7:0] s, d;
    for (int i = 0; i < n; i++) begin
      bit ok = 0;
      for (int t = 0; t < 80 && !ok; t++) begin a_get(3'd5, s); ok = s[0]; end
      chk({req, " R4 data ready"}, {7'd0, ok}, 8'h01);
      if (ok) begin
        a_get(3'd0, d);
        chk(req, d, q_ba.size() ? q_ba.pop_front() : 8'hxx);
      end
    end
    a_rel();
  endtask

  task automatic run_a(int n_tx, int n_rx);
    int sent = 0, got = 0;
    logic [7:0] s, d;
    while (sent < n_tx || got < n_rx) begin
      if (sent < n_tx && q_ab.size() < 10 && $urandom_range(1, 0) == 1) begin
        int len = $urandom_range(4, 1);
        for (int k = 0; k < len && sent < n_tx && q_ab.size() < 10; k++) begin
          d = 8'($urandom); q_ab.push_back(d); a_put(3'd0, d); sent++;
        end
      end else begin
        a_get(3'd5, s);
        if (s[0]) begin
          a_get(3'd0, d);
          chk("R3 random", d, q_ba.size() ? q_ba.pop_front() : 8'hxx);
          got++;
        end
      end
    end
    a_rel();
  endtask

  task automatic run_b(int n_tx, int n_rx);
    int sent = 0, got = 0;
    logic [7:0] s, d;
    while (sent < n_tx || got < n_rx) begin
      if (sent < n_tx && q_ba.size() < 10 && $urandom_range(1, 0) == 1) begin
        int len = $urandom_range(4, 1);
        for (int k = 0; k < len && sent < n_tx && q_ba.size() < 10; k++) begin
          d = 8'($urandom); q_ba.push_back(d); b_put(3'd0, d); sent++;
        end
      end else begin
        b_get(3'd5, s);
        if (s[0]) begin
          b_get(3'd0, d);
          chk("R2 random", d, q_ab.size() ? q_ab.pop_front() : 8'hxx);
          got++;
        end
      end
    end
    b_rel();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] s, d;
    repeat (5) @(negedge clk_b);
    rst_a_n = 1; rst_b_n = 1;
    repeat (3) @(negedge clk_b);

    a_get(3'd5, s); chk("R1 lsr A", s, 8'h60);
    a_get(3'd0, s); chk("R1 rbr A", s, 8'h00);
    a_rel();
    b_get(3'd5, s); chk("R1 lsr B", s, 8'h60);
    b_get(3'd0, s); chk("R1 rbr B", s, 8'h00);
    b_rel();

    for (int i = 0; i < 10; i++) begin d = 8'h30 + 8'(i); q_ab.push_back(d); a_put(3'd0, d); end
    a_get(3'd5, s); chk("R5 thre after burst", s & 8'h60, 8'h00);
    a_rel();
    b_drain("R2 burst", 10);
    b_get(3'd5, s); chk("R4 dr clear after drain", s & 8'h01, 8'h00);
    b_rel();
    repeat (10) @(negedge clk_a);
    a_get(3'd5, s); chk("R5 thre back", s, 8'h60);
    a_rel();

    for (int i = 0; i < 10; i++) begin d = 8'hA0 ^ 8'(i * 7); q_ba.push_back(d); b_put(3'd0, d); end
    b_get(3'd5, s); chk("R5 thre B after burst", s & 8'h60, 8'h00);
    b_rel();
    a_drain("R3 burst", 10);
    repeat (4) @(negedge clk_b);
    b_get(3'd5, s); chk("R5 thre B back", s, 8'h60);
    b_rel();

    for (int i = 0; i < 20; i++) begin
      d = 8'h50 + 8'(i);
      if (i < 16) q_ab.push_back(d);
      a_put(3'd0, d);
    end
    a_rel();
    repeat (4) @(negedge clk_b);
    b_drain("R6 depth", 16);
    b_get(3'd5, s); chk("R6 discarded byte absent", s & 8'h01, 8'h00);
    b_get(3'd0, s); chk("R7 empty read", s, 8'h00);
    b_get(3'd0, s); chk("R7 empty read again", s, 8'h00);
    b_rel();
    for (int i = 0; i < 3; i++) begin d = 8'hC0 + 8'(i); q_ab.push_back(d); a_put(3'd0, d); end
    a_rel();
    b_drain("R7 order after empty read", 3);

    for (int i = 0; i < 8; i++) begin
      d = 8'h11 * 8'(i + 1); q_ab.push_back(d); a_put(3'd0, d); a_get(3'd5, s);
    end
    a_rel();
    b_drain("R10 interleaved", 8);

    for (int i = 0; i < 5; i++) a_put(3'd0, 8'hE0 + 8'(i));
    a_rel();
    repeat (6) @(negedge clk_b);
    b_get(3'd5, s); chk("R8 dr before clear", s & 8'h01, 8'h01);
    b_put(3'd2, 8'h02);
    b_get(3'd5, s); chk("R8 dr after rx clear", s & 8'h01, 8'h00);
    b_rel();
    repeat (12) @(negedge clk_b);
    a_get(3'd5, s); chk("R8 thre after rx clear", s, 8'h60);
    a_rel();
    d = 8'h5A; q_ab.push_back(d); a_put(3'd0, d); a_rel();
    b_drain("R8 delivery after clear", 1);

    for (int i = 0; i < 5; i++) a_put(3'd0, 8'hF0 + 8'(i));
    a_rel();
    repeat (10) @(negedge clk_a);
    a_put(3'd2, 8'h04);
    a_rel();
    repeat (20) @(negedge clk_b);
    b_get(3'd5, s); chk("R9 dr after tx clear", s & 8'h01, 8'h00);
    b_rel();
    repeat (4) @(negedge clk_a);
    a_get(3'd5, s); chk("R9 thre after tx clear", s, 8'h60);
    a_rel();

    fork
      run_a(200, 200);
      run_b(200, 200);
    join
    repeat (10) @(negedge clk_b);
    a_get(3'd5, s); chk("R5 A idle after random", s, 8'h60);
    a_rel();
    b_get(3'd5, s); chk("R5 B idle after random", s, 8'h60);
    b_rel();
    summary();
  end
endmodule